// File: doc/BRIEF.md
# Reuleaux Triangle Outline Plotter

This block draws the outline of a Reuleaux triangle, with one vertex pointing up, into a pixel-addressed frame store. It takes a centre point, an even diameter D and a colour. It first works out the three vertices of the inscribed equilateral triangle in integer fixed point. It then traces three circles of radius D, one centred on each vertex, and writes only the arc of each circle that forms one side of the figure. It produces at most one pixel write per clock and never writes outside a 160 by 120 screen.

The block is driven by a level handshake. The user raises `start` and keeps it high, with the inputs stable, until `done` rises. When `start` falls, `done` falls one clock later, and a new `start` is accepted on the next cycle. Each circle is stepped with an integer midpoint algorithm that spends eight cycles per iteration, one for each octant.

Top module: `reu_plotter`

## Requirements
- R1: While `rst_n` is low, and right after it goes low in the middle of a drawing, `done` and `pix_we` are 0. After reset is released the block stays idle until `start` is seen high.
- R2: The vertices are: right vertex (cx + D/2, cy + round(D·√3/6)), left vertex (cx − D/2, cy + round(D·√3/6)), top vertex (cx, round(cy − D·√3/3)). Rounding is to the nearest integer, giving the same integer as converting the real-valued expression.
- R3: Three circles of radius D are traced in this order: centred on the right vertex, then the left vertex, then the top vertex. Each circle starts from offsets (D, 0) with decision value 1 − D. Each iteration visits the eight octant points while offset_y ≤ offset_x. Every point that passes R4 and R5 is written.
- R4: Arc masks use only vertex coordinates. The circle on the right vertex writes points with x ≤ top-vertex x and y ≤ right-vertex y. The circle on the left vertex writes points with x ≥ top-vertex x and y ≤ right-vertex y. The circle on the top vertex writes points with y ≥ right-vertex y. No other pixel is written.
- R5: A point with x outside 0..159 or y outside 0..119 is never written. `pix_x` is always below 160 and `pix_y` below 119+1 whenever `pix_we` is 1.
- R6: Every write carries the colour presented with `start`. At most one pixel is written per clock.
- R7: `done` is high no later than 24·N + 15 clock cycles after the cycle in which `start` is first seen. N is the number of iterations one circle of radius D takes.
- R8: `done` stays high while `start` stays high, and drops in the cycle after `start` is seen low. A `start` raised again on the very next cycle begins a new drawing.
- R9: No pixel is written while the block is idle or while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; held high until `done` |
| colour | input | 3 | Drawing colour |
| org_x | input | 8 | Centre x coordinate |
| org_y | input | 7 | Centre y coordinate |
| diam | input | 8 | Diameter D (even) |
| done | output | 1 | Drawing finished |
| pix_x | output | 8 | Pixel x coordinate |
| pix_y | output | 7 | Pixel y coordinate |
| pix_colour | output | 3 | Pixel colour |
| pix_we | output | 1 | Pixel write strobe |

## Verification
The bench builds the block with its default parameters: a 160 by 120 screen, an 8-bit diameter and 24 fraction bits for √3. With these, the whole diameter range up to 254 and centres on or beyond every screen edge can be swept. For every drawing, the bench compares the full screen bitmap of writes against an expected bitmap. It builds that expected bitmap from real-valued vertex equations and its own midpoint trace. This exposes any single misplaced, missing, unmasked or off-screen pixel, as well as the cycle budget and the handshake edges around each run.

// File: rtl/reu_pkg.sv
package reu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DRAW,
    ST_DONE
  } reu_state_e;

  // Integer square root, floor, evaluated at elaboration for constants.
  function automatic logic [63:0] isqrt64(input logic [63:0] v);
    logic [63:0] rem;
    logic [63:0] res;
    logic [63:0] bitv;
    rem  = v;
    res  = '0;
    bitv = 64'h1 << 62;
    for (int i = 0; i < 32; i++) begin
      if (rem >= res + bitv) begin
        rem = rem - (res + bitv);
        res = (res >> 1) + bitv;
      end else begin
        res = res >> 1;
      end
      bitv = bitv >> 2;
    end
    return res;
  endfunction

endpackage

// File: rtl/reu_corners.sv
module reu_corners
  import reu_pkg::*;
#(
  parameter int XW   = 8,
  parameter int YW   = 7,
  parameter int DW   = 8,
  parameter int SW   = 11,
  parameter int FRAC = 24
) (
  input  logic [XW-1:0]        cx,
  input  logic [YW-1:0]        cy,
  input  logic [DW-1:0]        diam,
  output logic signed [SW-1:0] c1x,
  output logic signed [SW-1:0] c1y,
  output logic signed [SW-1:0] c2x,
  output logic signed [SW-1:0] c2y,
  output logic signed [SW-1:0] c3x,
  output logic signed [SW-1:0] c3y
);

  localparam logic [63:0] ROOT3 = isqrt64(64'd3 << (2 * FRAC));
  localparam logic [63:0] K6    = (ROOT3 + 64'd3) / 64'd6;
  localparam logic [63:0] K3    = (ROOT3 + 64'd1) / 64'd3;
  localparam int          PW    = DW + FRAC + 1;
  localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);

  logic [PW-1:0]       p6, p3;
  logic [DW:0]         h6, h3;
  logic signed [SW-1:0] ex, ey, eh6, eh3, ehalf;

  // Rounded fixed-point products: D*sqrt3/6 and D*sqrt3/3
  assign p6 = PW'(diam) * K6[PW-1:0] + HALF;
  assign p3 = PW'(diam) * K3[PW-1:0] + HALF;
  assign h6 = p6[PW-1:FRAC];
  assign h3 = p3[PW-1:FRAC];

  assign ex    = $signed(SW'(cx));
  assign ey    = $signed(SW'(cy));
  assign eh6   = $signed(SW'(h6));
  assign eh3   = $signed(SW'(h3));
  assign ehalf = $signed(SW'(diam >> 1));

  assign c1x = ex + ehalf;
  assign c1y = ey + eh6;
  assign c2x = ex - ehalf;
  assign c2y = ey + eh6;
  assign c3x = ex;
  assign c3y = ey - eh3;

  // The two separately rounded heights differ by a factor of two within one unit
  always_comb begin
    if (!$isunknown(diam)) begin
      assert_height_ratio_R2: assert ((eh3 - (eh6 <<< 1)) >= -1 && (eh3 - (eh6 <<< 1)) <= 1)
        else $error("vertex heights inconsistent");
    end
  end

endmodule

// File: rtl/reu_circle_step.sv
module reu_circle_step #(
  parameter int DW = 8,
  parameter int SW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic signed [SW-1:0] ctr_x,
  input  logic signed [SW-1:0] ctr_y,
  input  logic [DW-1:0]        radius,
  output logic signed [SW-1:0] px,
  output logic signed [SW-1:0] py,
  output logic                 last
);

  localparam logic signed [SW-1:0] ONE  = 1;
  localparam logic signed [SW-1:0] ZERO = 0;

  logic signed [SW-1:0] ox_q, oy_q, crit_q;
  logic signed [SW-1:0] ox_d, oy_d, crit_d;
  logic [2:0]           oct_q, oct_d;
  logic signed [SW-1:0] ox_n, oy_n, crit_n, rad_s;
  logic signed [SW-1:0] ax, ay;
  logic                 swap, xneg, yneg;

  assign rad_s = $signed(SW'(radius));

  // Midpoint update for the next iteration
  always_comb begin
    oy_n = oy_q + ONE;
    if (crit_q <= ZERO) begin
      ox_n   = ox_q;
      crit_n = crit_q + (oy_n <<< 1) + ONE;
    end else begin
      ox_n   = ox_q - ONE;
      crit_n = crit_q + ((oy_n - ox_n) <<< 1) + ONE;
    end
  end

  assign last = step && (oct_q == 3'd7) && (oy_n > ox_n);

  always_comb begin
    ox_d   = ox_q;
    oy_d   = oy_q;
    crit_d = crit_q;
    oct_d  = oct_q;
    if (load) begin
      ox_d   = rad_s;
      oy_d   = ZERO;
      crit_d = ONE - rad_s;
      oct_d  = 3'd0;
    end else if (step) begin
      oct_d = oct_q + 3'd1;
      if (oct_q == 3'd7) begin
        ox_d   = ox_n;
        oy_d   = oy_n;
        crit_d = crit_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ox_q   <= '0;
      oy_q   <= '0;
      crit_q <= '0;
      oct_q  <= '0;
    end else if (load || step) begin
      ox_q   <= ox_d;
      oy_q   <= oy_d;
      crit_q <= crit_d;
      oct_q  <= oct_d;
    end
  end

  // Octant point selection
  assign swap = oct_q[0];
  assign xneg = oct_q[1] ^ oct_q[2];
  assign yneg = oct_q[2];
  assign ax   = swap ? oy_q : ox_q;
  assign ay   = swap ? ox_q : oy_q;
  assign px   = xneg ? (ctr_x - ax) : (ctr_x + ax);
  assign py   = yneg ? (ctr_y - ay) : (ctr_y + ay);

  assert_offsets_ordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (oy_q <= ox_q && oy_q >= ZERO));

endmodule

// File: rtl/reu_arc_gate.sv
module reu_arc_gate #(
  parameter int XW    = 8,
  parameter int YW    = 7,
  parameter int SW    = 11,
  parameter int SCR_W = 160,
  parameter int SCR_H = 120
) (
  input  logic                 active,
  input  logic [1:0]           cix,
  input  logic signed [SW-1:0] px,
  input  logic signed [SW-1:0] py,
  input  logic signed [SW-1:0] top_x,
  input  logic signed [SW-1:0] base_y,
  output logic                 we,
  output logic [XW-1:0]        wx,
  output logic [YW-1:0]        wy
);

  localparam logic signed [SW-1:0] LIM_X = SW'(SCR_W);
  localparam logic signed [SW-1:0] LIM_Y = SW'(SCR_H);
  localparam logic signed [SW-1:0] ZERO  = 0;

  logic onscr, on_arc;

  assign onscr = (px >= ZERO) && (px < LIM_X) && (py >= ZERO) && (py < LIM_Y);

  always_comb begin
    unique case (cix)
      2'd0:    on_arc = (px <= top_x) && (py <= base_y);
      2'd1:    on_arc = (px >= top_x) && (py <= base_y);
      2'd2:    on_arc = (py >= base_y);
      default: on_arc = 1'b0;
    endcase
  end

  assign we = active && onscr && on_arc;
  assign wx = px[XW-1:0];
  assign wy = py[YW-1:0];

endmodule

// File: rtl/reu_plotter.sv
module reu_plotter
  import reu_pkg::*;
#(
  parameter int XW    = 8,
  parameter int YW    = 7,
  parameter int DW    = 8,
  parameter int CW    = 3,
  parameter int SCR_W = 160,
  parameter int SCR_H = 120,
  parameter int FRAC  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] colour,
  input  logic [XW-1:0] org_x,
  input  logic [YW-1:0] org_y,
  input  logic [DW-1:0] diam,
  output logic          done,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic [CW-1:0] pix_colour,
  output logic          pix_we
);

  localparam int MXY = (XW > YW) ? XW : YW;
  localparam int SW  = ((MXY > DW) ? MXY : DW) + 3;

  reu_state_e           state_q, state_d;
  logic [1:0]           cix_q, cix_d;
  logic [XW-1:0]        lx_q;
  logic [YW-1:0]        ly_q;
  logic [DW-1:0]        ld_q;
  logic [CW-1:0]        lc_q;
  logic                 take;
  logic signed [SW-1:0] c1x, c1y, c2x, c2y, c3x, c3y;
  logic signed [SW-1:0] mx, my, px, py;
  logic                 load, step, last;

  assign take = (state_q == ST_IDLE) && start;

  // Sequencer
  always_comb begin
    state_d = state_q;
    cix_d   = cix_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_LOAD;
        cix_d   = 2'd0;
      end
      ST_LOAD: state_d = ST_DRAW;
      ST_DRAW: if (last) begin
        if (cix_q == 2'd2) begin
          state_d = ST_DONE;
        end else begin
          cix_d   = cix_q + 2'd1;
          state_d = ST_LOAD;
        end
      end
      ST_DONE: if (!start) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cix_q   <= '0;
    end else begin
      state_q <= state_d;
      cix_q   <= cix_d;
    end
  end

  // Request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lx_q <= '0;
      ly_q <= '0;
      ld_q <= '0;
      lc_q <= '0;
    end else if (take) begin
      lx_q <= org_x;
      ly_q <= org_y;
      ld_q <= diam;
      lc_q <= colour;
    end
  end

  reu_corners #(.XW(XW), .YW(YW), .DW(DW), .SW(SW), .FRAC(FRAC)) u_corners (
    .cx(lx_q), .cy(ly_q), .diam(ld_q),
    .c1x(c1x), .c1y(c1y), .c2x(c2x), .c2y(c2y), .c3x(c3x), .c3y(c3y)
  );

  always_comb begin
    unique case (cix_q)
      2'd0:    begin mx = c1x; my = c1y; end
      2'd1:    begin mx = c2x; my = c2y; end
      default: begin mx = c3x; my = c3y; end
    endcase
  end

  assign load = (state_q == ST_LOAD);
  assign step = (state_q == ST_DRAW);

  reu_circle_step #(.DW(DW), .SW(SW)) u_step (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .ctr_x(mx), .ctr_y(my), .radius(ld_q),
    .px(px), .py(py), .last(last)
  );

  reu_arc_gate #(.XW(XW), .YW(YW), .SW(SW), .SCR_W(SCR_W), .SCR_H(SCR_H)) u_gate (
    .active(step), .cix(cix_q), .px(px), .py(py),
    .top_x(c3x), .base_y(c1y),
    .we(pix_we), .wx(pix_x), .wy(pix_y)
  );

  assign pix_colour = lc_q;
  assign done       = (state_q == ST_DONE);

  assert_on_screen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |-> (pix_x < SCR_W && pix_y < SCR_H));

  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pix_we);

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  assert_done_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> !$past(start));

  assert_colour_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_we && $past(pix_we)) |-> $stable(pix_colour));

endmodule

// File: tb/sim_reu_plotter.sv
module sim_reu_plotter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] colour;
  logic [7:0] org_x;
  logic [6:0] org_y;
  logic [7:0] diam;
  logic       done;
  logic [7:0] pix_x;
  logic [6:0] pix_y;
  logic [2:0] pix_colour;
  logic       pix_we;

  int total = 0;
  int bad   = 0;

  bit got_m [160][120];
  bit exp_m [160][120];

  always #5 clk = ~clk;

  reu_plotter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .colour(colour),
    .org_x(org_x), .org_y(org_y), .diam(diam),
    .done(done), .pix_x(pix_x), .pix_y(pix_y),
    .pix_colour(pix_colour), .pix_we(pix_we)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Marks an expected pixel if it lies on the arc (R4) and on screen (R5)
  function automatic void mark(input int x, input int y, input int k,
                               input int topx, input int basey);
    bit keep;
    case (k)
      0:       keep = (x <= topx) && (y <= basey);
      1:       keep = (x >= topx) && (y <= basey);
      default: keep = (y >= basey);
    endcase
    if (keep && x >= 0 && x < 160 && y >= 0 && y < 120) exp_m[x][y] = 1'b1;
  endfunction

  // Midpoint trace of one circle of radius d (R3); returns iteration count
  function automatic int trace(input int ax, input int ay, input int d, input int k,
                               input int topx, input int basey);
    int ox = d;
    int oy = 0;
    int crit = 1 - d;
    int n = 0;
    while (oy <= ox) begin
      mark(ax + ox, ay + oy, k, topx, basey);
      mark(ax + oy, ay + ox, k, topx, basey);
      mark(ax - ox, ay + oy, k, topx, basey);
      mark(ax - oy, ay + ox, k, topx, basey);
      mark(ax - ox, ay - oy, k, topx, basey);
      mark(ax - oy, ay - ox, k, topx, basey);
      mark(ax + ox, ay - oy, k, topx, basey);
      mark(ax + oy, ay - ox, k, topx, basey);
      n++;
      oy++;
      if (crit <= 0) crit = crit + 2 * oy + 1;
      else begin
        ox--;
        crit = crit + 2 * (oy - ox) + 1;
      end
    end
    return n;
  endfunction

  task automatic run_case(input int cx, input int cy, input int d, input int col);
    int x1, y1, x2, x3, y3, n, cyc, offscr, colbad, missing, extra;
    bit fin;
    // R2: vertices from real-valued equations, rounded by conversion
    x1 = cx + d / 2;
    x2 = cx - d / 2;
    x3 = cx;
    y1 = int'(real'(cy) + real'(d) * $sqrt(3.0) / 6.0);
    y3 = int'(real'(cy) - real'(d) * $sqrt(3.0) / 3.0);
    for (int i = 0; i < 160; i++)
      for (int j = 0; j < 120; j++) begin
        exp_m[i][j] = 1'b0;
        got_m[i][j] = 1'b0;
      end
    n = trace(x1, y1, d, 0, x3, y1);
    void'(trace(x2, y1, d, 1, x3, y1));
    void'(trace(x3, y3, d, 2, x3, y1));

    @(negedge clk);
    org_x  = 8'(cx);
    org_y  = 7'(cy);
    diam   = 8'(d);
    colour = 3'(col);
    start  = 1'b1;
    cyc = 0; offscr = 0; colbad = 0; fin = 1'b0;
    while (!fin && cyc < 24 * n + 200) begin
      @(negedge clk);
      cyc++;
      if (pix_we) begin
        if (pix_x >= 160 || pix_y >= 120) offscr++;
        else got_m[pix_x][pix_y] = 1'b1;
        if (pix_colour != 3'(col)) colbad++;
      end
      if (done) fin = 1'b1;
    end
    chk(fin, "R7", "watchdog, done seen", int'(fin), 1);
    chk(cyc <= 24 * n + 15, "R7", "cycles to done", cyc, 24 * n + 15);
    missing = 0; extra = 0;
    for (int i = 0; i < 160; i++)
      for (int j = 0; j < 120; j++) begin
        if (exp_m[i][j] && !got_m[i][j]) missing++;
        if (!exp_m[i][j] && got_m[i][j]) extra++;
      end
    chk(missing == 0, "R2 R3", "arc pixels not written", missing, 0);
    chk(extra == 0, "R4", "pixels written off the arcs", extra, 0);
    chk(offscr == 0, "R5", "off-screen writes", offscr, 0);
    chk(colbad == 0, "R6", "writes with wrong colour", colbad, 0);
    // R8 / R9: done held, no writes while start stays high
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(done == 1'b1, "R8", "done held with start high", int'(done), 1);
      chk(pix_we == 1'b0, "R9", "write while done", int'(pix_we), 0);
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done after start low", int'(done), 0);
    chk(pix_we == 1'b0, "R9", "write while idle", int'(pix_we), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; colour = '0; org_x = '0; org_y = '0; diam = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && pix_we == 1'b0, "R1", "outputs in reset",
        int'({done, pix_we}), 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(done == 1'b0 && pix_we == 1'b0, "R1", "idle after reset",
          int'({done, pix_we}), 0);
    end

    // Diameter sweep around screen centre
    for (int d = 0; d <= 120; d += 4) run_case(80, 60, d, (d / 4) % 8);
    // Edges, corners and large diameters
    run_case(0, 0, 60, 1);
    run_case(159, 119, 60, 2);
    run_case(5, 100, 140, 3);
    run_case(150, 10, 200, 4);
    run_case(255, 127, 254, 5);
    run_case(80, 60, 254, 6);
    run_case(40, 30, 2, 7);
    run_case(120, 0, 98, 2);

    // R1: reset in the middle of a drawing
    @(negedge clk);
    org_x = 8'd80; org_y = 7'd60; diam = 8'd80; colour = 3'd2; start = 1'b1;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(done == 1'b0 && pix_we == 1'b0, "R1", "outputs after mid-draw reset",
        int'({done, pix_we}), 0);
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(pix_we == 1'b0 && done == 1'b0, "R1", "idle after mid-draw reset",
          int'({done, pix_we}), 0);
    end
    run_case(80, 60, 80, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule